// File: doc/BRIEF.md
# Interrupt Source Router

A chip has more event-producing peripherals than its CPU has maskable interrupt inputs. This block takes sixteen event lines (host port, two timers, memory refresh, four external pins, four DMA channels and two serial ports, each with its own transmit and receive line) and drives twelve CPU interrupt lines, INT4 to INT15. Each CPU line has a 4-bit source code. Software sets that code through a small 32-bit register bus, so any event can be steered to any CPU line, and one event can drive several lines at once.

Two mapping registers hold the twelve source codes, six to a register, in a packed layout that leaves gaps. A third register sets the polarity of the four external pins. Polarity inversion acts only on the path to the CPU. The sixteen event lines also leave the block unchanged for a DMA-side consumer. Reads are combinational from the address. Writes take effect on the clock edge that samples them.

Top module: `irq_src_router`

## Requirements
- R1: After reset, CPU line INTn selects source code n for every n from 4 to 15, and the polarity register reads 0. The register at offset 4 reads 0x250718A4 and the register at offset 0 reads 0x3DCD316A.
- R2: In each mapping register the six 4-bit codes sit at bits 3:0, 8:5, 13:10, 19:16, 24:21 and 29:26. All other bits read as zero, and writing ones to them has no effect.
- R3: The register at byte offset 0 holds INT10..INT15 and the one at offset 4 holds INT4..INT9, in ascending line order from the lowest field. cpu_irq bit k carries INT(k+4). Writing 5 into bits 13:10 at offset 0 maps external pin 5 onto INT12.
- R4: Each cpu_irq bit equals the selected event after polarity treatment. An event whose code is outside 4..7 passes to the CPU uninverted.
- R5: Source code c corresponds to evt_in bit c. The codes are: 0 host port, 1 and 2 the timers, 3 refresh, 4..7 external pins 4..7, 8..11 DMA channels 0..3, 12/13 serial port 0 transmit/receive, 14/15 serial port 1 transmit/receive.
- R6: The register at offset 8 holds one polarity bit per external pin, bits 0..3 for pins 4..7. A 0 passes the pin through. A 1 inverts it on the CPU path. Bits 31:4 read zero.
- R7: evt_raw always equals evt_in, whatever the polarity setting.
- R8: A write changes outputs only after the clock edge that samples it. Writes to any offset other than 0, 4 and 8 change nothing, and reads from such an offset return 0.
- R9: The same source code may be placed in any number of fields, and every line that selects it follows that event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr |
| evt_in | input | 16 | Event lines, bit index = source code |
| cpu_irq | output | 12 | Routed CPU lines, bit k = INT(k+4) |
| evt_raw | output | 16 | Uninverted copy of the event lines |

## Verification
The assertions check on every cycle the following properties:
- reserved bits of the mapping registers read as zero;
- a cycle without a write leaves the readback unchanged;
- a polarity write lands in the register on the next cycle;
- a polarity write never disturbs the raw event outputs.

Only the bench's scenarios can show the rest:
- the routing of each line under full, reversed, collapsed and default mappings;
- the inversion of external pins on the CPU path alone;
- the split of the lines between the two registers;
- the exact cycle on which a new mapping becomes visible.

// File: rtl/irq_src_router.sv
module irq_src_router #(
  parameter int NUM_SRC   = 16,
  parameter int NUM_LINES = 12,
  parameter int SEL_W     = 4,
  parameter int DW        = 32,
  parameter int AW        = 4,
  parameter int EXT_LO    = 4,
  parameter int EXT_N     = 4,
  parameter int LINE_BASE = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [AW-1:0]        addr,
  input  logic [DW-1:0]        wdata,
  output logic [DW-1:0]        rdata,
  input  logic [NUM_SRC-1:0]   evt_in,
  output logic [NUM_LINES-1:0] cpu_irq,
  output logic [NUM_SRC-1:0]   evt_raw
);
  localparam int FIELDS = NUM_LINES / 2;
  localparam logic [AW-1:0] OFS_HI  = AW'(0);
  localparam logic [AW-1:0] OFS_LO  = AW'(4);
  localparam logic [AW-1:0] OFS_POL = AW'(8);

  function automatic int field_lsb(input int k);
    return k * (SEL_W + 1) + ((k >= FIELDS / 2) ? 1 : 0);
  endfunction

  function automatic logic [DW-1:0] field_mask();
    logic [DW-1:0] m = '0;
    for (int k = 0; k < FIELDS; k++) m[field_lsb(k) +: SEL_W] = '1;
    return m;
  endfunction

  localparam logic [DW-1:0] FMASK = field_mask();

  logic [SEL_W-1:0]   sel_q [NUM_LINES];
  logic [EXT_N-1:0]   pol_q;
  logic [NUM_SRC-1:0] evt_cpu;
  logic [DW-1:0]      rd_lo, rd_hi;
  logic               unused_wdata;

  assign unused_wdata = ^(wdata & ~FMASK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_LINES; i++) sel_q[i] <= SEL_W'(i + LINE_BASE);
      pol_q <= '0;
    end else if (wr_en) begin
      case (addr)
        OFS_HI:  for (int k = 0; k < FIELDS; k++) sel_q[FIELDS+k] <= wdata[field_lsb(k) +: SEL_W];
        OFS_LO:  for (int k = 0; k < FIELDS; k++) sel_q[k] <= wdata[field_lsb(k) +: SEL_W];
        OFS_POL: pol_q <= wdata[EXT_N-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_lo = '0;
    rd_hi = '0;
    for (int k = 0; k < FIELDS; k++) begin
      rd_lo[field_lsb(k) +: SEL_W] = sel_q[k];
      rd_hi[field_lsb(k) +: SEL_W] = sel_q[FIELDS+k];
    end
    case (addr)
      OFS_HI:  rdata = rd_hi;
      OFS_LO:  rdata = rd_lo;
      OFS_POL: rdata = DW'(pol_q);
      default: rdata = '0;
    endcase
  end

  assign evt_cpu = evt_in ^ (NUM_SRC'(pol_q) << EXT_LO);
  assign evt_raw = evt_in;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    assign cpu_irq[g] = evt_cpu[sel_q[g]];
  end

  p_resv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == OFS_HI || addr == OFS_LO) |-> ((rdata & ~FMASK) == '0));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(addr) -> $stable(rdata)));

  p_pol_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_POL) |=>
      ((addr == OFS_POL) -> (rdata == DW'($past(wdata[EXT_N-1:0])))));

  p_raw_untouched_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_POL) |=> ($stable(evt_in) -> $stable(evt_raw)));
endmodule

// File: tb/sim_irq_src_router.sv
module sim_irq_src_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] evt_in = '0;
  logic [11:0] cpu_irq;
  logic [15:0] evt_raw;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_src_router u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .evt_in(evt_in), .cpu_irq(cpu_irq), .evt_raw(evt_raw));

  localparam int LSB [6] = '{0, 5, 10, 16, 21, 26};

  // {lo, hi, pol, evt}
  localparam logic [83:0] VEC [6] = '{
    {32'h250718A4, 32'h3DCD316A, 4'h0, 16'hA5C3},
    {32'h00000000, 32'h00000000, 4'h0, 16'h0001},
    {32'h14A528A5, 32'h14A528A5, 4'h2, 16'h0020},
    {32'h14A528A5, 32'h14A528A5, 4'hF, 16'h0000},
    {32'h296C35CF, 32'h10A61D09, 4'h9, 16'h3C96},
    {32'hFFFFFFFF, 32'hC3A5F00F, 4'hA, 16'h8421}
  };

  function automatic logic [31:0] fmask();
    logic [31:0] m = '0;
    for (int k = 0; k < 6; k++) m[LSB[k] +: 4] = 4'hF;
    return m;
  endfunction

  function automatic logic [11:0] model(input logic [31:0] lo, input logic [31:0] hi,
                                        input logic [3:0] pol, input logic [15:0] evt);
    logic [11:0] r;
    logic [15:0] pe;
    logic [3:0]  c;
    pe = evt;
    for (int p = 0; p < 4; p++) if (pol[p]) pe[4+p] = ~evt[4+p];
    for (int n = 0; n < 12; n++) begin
      c = (n < 6) ? lo[LSB[n] +: 4] : hi[LSB[n-6] +: 4];
      r[n] = pe[c];
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    #800000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] m;
    m = fmask();
    do_reset();

    rd(4'd4, d); chk("R1 lo reset", d, 32'h250718A4);
    rd(4'd0, d); chk("R1 hi reset", d, 32'h3DCD316A);
    rd(4'd8, d); chk("R1 pol reset", d, 32'h0);
    evt_in = 16'hF0F0; #1;
    chk("R1 R5 default routing", {20'h0, cpu_irq}, {20'h0, 12'hF0F});

    for (int v = 0; v < 6; v++) begin
      logic [31:0] lo, hi;
      logic [3:0]  pol;
      logic [15:0] evt;
      {lo, hi, pol, evt} = VEC[v];
      wr(4'd4, lo); wr(4'd0, hi); wr(4'd8, {28'hFFFFFFF, pol});
      evt_in = evt;
      rd(4'd4, d); chk("R2 R3 lo readback", d, lo & m);
      rd(4'd0, d); chk("R2 R3 hi readback", d, hi & m);
      rd(4'd8, d); chk("R6 pol readback", d, {28'h0, pol});
      chk("R4 R6 R9 routing", {20'h0, cpu_irq}, {20'h0, model(lo, hi, pol, evt)});
      chk("R7 raw passthrough", {16'h0, evt_raw}, {16'h0, evt});
    end

    do_reset();
    wr(4'd0, 32'h3DCD156A);
    evt_in = 16'h0020; #1;
    chk("R3 pin5 onto INT12", {20'h0, cpu_irq}, {20'h0, 12'h102});
    wr(4'd8, 32'h2); #1;
    chk("R6 pin5 inverted", {20'h0, cpu_irq}, {20'h0, 12'h000});
    chk("R7 raw not inverted", {16'h0, evt_raw}, 32'h0020);
    evt_in = 16'h0001; #1;
    chk("R4 host port not inverted", {20'h0, cpu_irq}, {20'h0, 12'h102});

    @(negedge clk);
    wr_en = 1'b1; addr = 4'd0; wdata = 32'h0;
    #1 chk("R8 before edge", {20'h0, cpu_irq}, {20'h0, 12'h102});
    @(negedge clk);
    wr_en = 1'b0;
    #1 chk("R8 after edge", {20'h0, cpu_irq}, {20'h0, 12'hFC2});

    wr(4'd12, 32'hFFFFFFFF);
    rd(4'd12, d); chk("R8 unmapped reads zero", d, 32'h0);
    rd(4'd0, d); chk("R8 unmapped write ignored hi", d, 32'h0);
    rd(4'd4, d); chk("R8 unmapped write ignored lo", d, 32'h250718A4);
    rd(4'd8, d); chk("R8 unmapped write ignored pol", d, 32'h2);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule